// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block connects two 18-bit ports, A and B, and carries data in both directions. Each direction has a single storage element. It works in one of three modes, chosen by that direction's latch-enable level and clock input:

- **Pass:** the far port follows the near port directly.
- **Keep:** the stored word is held.
- **Capture:** a rising edge on the per-direction clock loads the near port into storage.

Each direction also has an output enable that decides whether the far port is driven. The A-to-B enable is active high. The B-to-A enable is active low.

All logic sits in one system-clock domain. The per-direction clocks are plain data inputs, and a rising edge on one is detected against its previous sample. Tri-state pins appear as separate data-in, data-out and drive-enable signals. The surrounding chip resolves those signals onto a shared wire. The 18 bit channels are independent but share one set of controls per direction.

Top module: `bxcv_top`

## Requirements
- R1: While a direction's latch enable is high, its far-port data output equals its near-port data input in the same cycle (combinational pass).
- R2: While the latch enable is low and no rising edge of that direction's clock is sampled, the far-port data output stays unchanged from cycle to cycle.
- R3: With the latch enable low, a system-clock cycle in which the per-direction clock is sampled high after being sampled low captures the near-port input. The far-port output shows that value from the next cycle on.
- R4: A falling edge of the per-direction clock with the latch enable low captures nothing. The output keeps its previous value.
- R5: `b_drive_en` is 1 exactly when `oe_ab` is 1 and reset is not asserted.
- R6: `a_drive_en` is 1 exactly when `oe_ba_n` is 0 and reset is not asserted.
- R7: B-to-A flow behaves as in R1 to R4 using `le_ba`, `clk_ba` and `b_data_in`, independently of the A-to-B controls.
- R8: During reset both drive enables are 0 whatever the enables are, and both stored words become all zeros.
- R9: A cycle with the latch enable high stores the pass value, even when a clock rise is sampled in the same cycle. After the latch enable falls, the output holds the input of the last cycle in which it was high.
- R10: A per-direction clock that is already high when reset is released is not taken as a rising edge. The stored word stays zero.
- R11: Each of the 18 bit channels carries its own bit only. A single set bit at any position appears only at that position of the far output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_data_in | input | 18 | Value seen on port A |
| a_data_out | output | 18 | Value offered to port A (B-to-A path) |
| a_drive_en | output | 1 | Drive port A when 1 |
| b_data_in | input | 18 | Value seen on port B |
| b_data_out | output | 18 | Value offered to port B (A-to-B path) |
| b_drive_en | output | 1 | Drive port B when 1 |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ab | input | 1 | A-to-B latch enable (1 = pass) |
| clk_ab | input | 1 | A-to-B capture clock, sampled |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| le_ba | input | 1 | B-to-A latch enable (1 = pass) |
| clk_ba | input | 1 | B-to-A capture clock, sampled |

## Verification
Walking-one words on both ports, under pass and under capture, separate a crossed or stuck channel from a correct one. Directed sequences cover several cases: a rise captured, a fall ignored, a clock rise in the same cycle as a pass, and a clock held high across reset release. Together they separate rising-edge capture from level capture and from capture on either edge. A long sweep draws pseudo-random control and data values for both directions at once and compares them against an arithmetic model. This shows that the two directions never disturb each other and that the output enables keep their opposite polarities.

// File: rtl/bxcv_pkg.sv
package bxcv_pkg;

   typedef enum logic [1:0] {
      MODE_PASS = 2'd0,
      MODE_KEEP = 2'd1,
      MODE_GRAB = 2'd2
   } store_mode_t;

   // Latch-enable level has priority over a sampled clock rise.
   function automatic store_mode_t pick_mode(input logic le, input logic rise);
      if (le)        return MODE_PASS;
      else if (rise) return MODE_GRAB;
      else           return MODE_KEEP;
   endfunction

endpackage

// File: rtl/bxcv_rise.sv
module bxcv_rise #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic sig_in,
   output logic rise
);
   logic sampled;
   logic prev;

   initial assert (SYNC_STAGES <= 4) else $error("SYNC_STAGES above 4");

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sampled = sig_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (rst) begin
               chain <= '1;
            end else begin
               chain[0] <= sig_in;
               for (int i = 1; i < int'(SYNC_STAGES); i++) chain[i] <= chain[i-1];
            end
         end
         assign sampled = chain[SYNC_STAGES-1];
      end
   endgenerate

   // Reset to one so that a clock already high at release is no edge.
   always_ff @(posedge clk) begin
      if (rst) prev <= 1'b1;
      else     prev <= sampled;
   end

   assign rise = sampled & ~prev;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise); // R3

endmodule

// File: rtl/bxcv_store.sv
module bxcv_store
   import bxcv_pkg::*;
#(
   parameter int unsigned WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             le,
   input  logic             rise,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   store_mode_t      mode;
   logic [WIDTH-1:0] q;

   initial assert (WIDTH >= 1) else $error("WIDTH must be positive");

   assign mode = pick_mode(le, rise);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         case (mode)
            MODE_PASS, MODE_GRAB: q <= din;
            default:              q <= q;
         endcase
      end
   end

   assign dout = (mode == MODE_PASS) ? din : q;

   AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (rst)
      (!le && !rise) |=> (le || $stable(dout))); // R2

endmodule

// File: rtl/bxcv_drive.sv
module bxcv_drive #(
   parameter int unsigned WIDTH          = 18,
   parameter bit          EN_ACTIVE_HIGH = 1'b1
) (
   input  logic             rst,
   input  logic             oe,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             den
);
   logic on;

   generate
      if (EN_ACTIVE_HIGH) begin : g_high
         assign on = oe;
      end else begin : g_low
         assign on = ~oe;
      end
   endgenerate

   assign den  = on & ~rst;
   assign dout = din;

endmodule

// File: rtl/bxcv_top.sv
module bxcv_top #(
   parameter int unsigned WIDTH       = 18,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a_data_in,
   output logic [WIDTH-1:0] a_data_out,
   output logic             a_drive_en,
   input  logic [WIDTH-1:0] b_data_in,
   output logic [WIDTH-1:0] b_data_out,
   output logic             b_drive_en,
   input  logic             oe_ab,
   input  logic             le_ab,
   input  logic             clk_ab,
   input  logic             oe_ba_n,
   input  logic             le_ba,
   input  logic             clk_ba
);
   logic             ab_rise, ba_rise;
   logic [WIDTH-1:0] ab_word, ba_word;

   initial assert (WIDTH >= 1 && WIDTH <= 1024) else $error("WIDTH out of range");

   // A to B
   bxcv_rise #(.SYNC_STAGES(SYNC_STAGES)) u_rise_ab (
      .clk(clk), .rst(rst), .sig_in(clk_ab), .rise(ab_rise));
   bxcv_store #(.WIDTH(WIDTH)) u_store_ab (
      .clk(clk), .rst(rst), .le(le_ab), .rise(ab_rise),
      .din(a_data_in), .dout(ab_word));
   bxcv_drive #(.WIDTH(WIDTH), .EN_ACTIVE_HIGH(1'b1)) u_drive_b (
      .rst(rst), .oe(oe_ab), .din(ab_word), .dout(b_data_out), .den(b_drive_en));

   // B to A
   bxcv_rise #(.SYNC_STAGES(SYNC_STAGES)) u_rise_ba (
      .clk(clk), .rst(rst), .sig_in(clk_ba), .rise(ba_rise));
   bxcv_store #(.WIDTH(WIDTH)) u_store_ba (
      .clk(clk), .rst(rst), .le(le_ba), .rise(ba_rise),
      .din(b_data_in), .dout(ba_word));
   bxcv_drive #(.WIDTH(WIDTH), .EN_ACTIVE_HIGH(1'b0)) u_drive_a (
      .rst(rst), .oe(oe_ba_n), .din(ba_word), .dout(a_data_out), .den(a_drive_en));

   AST_PASS_AB: assert property (@(posedge clk) disable iff (rst)
      le_ab |-> (b_data_out == a_data_in)); // R1
   AST_PASS_BA: assert property (@(posedge clk) disable iff (rst)
      le_ba |-> (a_data_out == b_data_in)); // R7
   AST_GRAB_AB: assert property (@(posedge clk) disable iff (rst)
      (!le_ab && ab_rise) ##1 !le_ab |-> (b_data_out == $past(a_data_in))); // R3
   AST_GRAB_BA: assert property (@(posedge clk) disable iff (rst)
      (!le_ba && ba_rise) ##1 !le_ba |-> (a_data_out == $past(b_data_in))); // R7
   AST_PASS_STORED_AB: assert property (@(posedge clk) disable iff (rst)
      le_ab |=> (le_ab || b_data_out == $past(a_data_in))); // R9
   AST_RST_QUIET: assert property (@(posedge clk)
      rst |-> (!a_drive_en && !b_drive_en)); // R8

endmodule

// File: tb/tb_bxcv_top.sv
module tb_bxcv_top;
   localparam int W = 18;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic oe_ab = 1'b1, le_ab = 1'b0, clk_ab = 1'b1;
   logic oe_ba_n = 1'b0, le_ba = 1'b0, clk_ba = 1'b1;
   logic [W-1:0] a_out, b_out;
   logic a_den, b_den;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model state
   logic [W-1:0] st_ab = '0, st_ba = '0;
   logic pc_ab = 1'b1, pc_ba = 1'b1;
   bit rose_ab = 1'b0, rose_ba = 1'b0;

   always #10 clk = ~clk;

   bxcv_top #(.WIDTH(W)) dut (
      .clk(clk), .rst(rst),
      .a_data_in(a_in), .a_data_out(a_out), .a_drive_en(a_den),
      .b_data_in(b_in), .b_data_out(b_out), .b_drive_en(b_den),
      .oe_ab(oe_ab), .le_ab(le_ab), .clk_ab(clk_ab),
      .oe_ba_n(oe_ba_n), .le_ba(le_ba), .clk_ba(clk_ba));

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic lab, input logic cab, input logic oab,
                       input logic lba, input logic cba, input logic obn,
                       input string tag);
      logic [W-1:0] eb, ea;
      @(negedge clk);
      a_in = a; b_in = b;
      le_ab = lab; clk_ab = cab; oe_ab = oab;
      le_ba = lba; clk_ba = cba; oe_ba_n = obn;
      #5;
      eb = lab ? a : st_ab;
      ea = lba ? b : st_ba;
      if (tag != "") begin
         chk({tag, " b_out"}, b_out, eb);
         chk({tag, " a_out"}, a_out, ea);
      end else begin
         chk(lab ? "R1 b_out" : (rose_ab ? "R3 b_out" : "R2 b_out"), b_out, eb);
         chk(lba ? "R7 a_out pass" : "R7 a_out hold", a_out, ea);
      end
      chk("R5 b_drive_en", {{(W-1){1'b0}}, b_den}, {{(W-1){1'b0}}, oab});
      chk("R6 a_drive_en", {{(W-1){1'b0}}, a_den}, {{(W-1){1'b0}}, ~obn});
      @(posedge clk);
      rose_ab = !lab && cab && !pc_ab;
      rose_ba = !lba && cba && !pc_ba;
      if (lab || (cab && !pc_ab)) st_ab = a;
      if (lba || (cba && !pc_ba)) st_ba = b;
      pc_ab = cab; pc_ba = cba;
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      // R8: reset with both enables asking to drive
      a_in = 18'h3FFFF; b_in = 18'h2AAAA;
      repeat (3) begin
         @(negedge clk); #5;
         chk("R8 b_drive_en in reset", {{(W-1){1'b0}}, b_den}, '0);
         chk("R8 a_drive_en in reset", {{(W-1){1'b0}}, a_den}, '0);
      end
      @(negedge clk); rst = 1'b0;
      // R10: clocks held high across release, R8: stored zero
      step(18'h3FFFF, 18'h2AAAA, 0, 1, 1, 0, 1, 0, "R10");
      step(18'h3FFFF, 18'h2AAAA, 0, 1, 1, 0, 1, 0, "R8");
      // R3: capture on rise
      step(18'h0F0F0, 18'h00001, 0, 0, 1, 0, 0, 0, "R2");
      step(18'h2AAAA, 18'h00002, 0, 1, 1, 0, 0, 0, "R3 edge cycle");
      step(18'h15555, 18'h00003, 0, 1, 1, 0, 0, 0, "R3");
      chk("R3 captured word", b_out, 18'h2AAAA);
      // R4: falling edge ignored
      step(18'h00F0F, 18'h00004, 0, 0, 1, 0, 0, 0, "R4");
      step(18'h00F0F, 18'h00004, 0, 0, 1, 0, 0, 0, "R4");
      chk("R4 no capture on fall", b_out, 18'h2AAAA);
      // R9: pass cycle with same-cycle rise
      step(18'h12345, 18'h00005, 1, 1, 1, 0, 0, 0, "R9");
      step(18'h00000, 18'h00005, 0, 1, 1, 0, 0, 0, "R9");
      chk("R9 held pass value", b_out, 18'h12345);
      // R5 / R6 polarity
      step(18'h00000, 18'h00005, 0, 1, 0, 0, 0, 1, "R5");
      step(18'h00000, 18'h00005, 0, 1, 1, 0, 0, 0, "R6");
      // R7: B to A independent of A to B
      step(18'h11111, 18'h3C3C3, 0, 1, 1, 1, 0, 0, "R7");
      step(18'h22222, 18'h0A0A0, 0, 1, 1, 0, 1, 0, "R7");
      step(18'h33333, 18'h05050, 0, 1, 1, 0, 1, 0, "R7");
      chk("R7 captured on B-to-A rise", a_out, 18'h0A0A0);
      chk("R7 A-to-B untouched", b_out, 18'h12345);
      // R11: walking ones, pass then capture
      for (int i = 0; i < W; i++) begin
         step(18'd1 << i, 18'd1 << (W - 1 - i), 1, 0, 1, 1, 0, 0, "R11");
         step(18'd0, 18'd0, 0, 1, 1, 0, 1, 0, "R11");
         step(18'd0, 18'd0, 0, 0, 1, 0, 0, 0, "R11");
         step(18'd1 << i, 18'd1 << (W - 1 - i), 0, 1, 1, 0, 1, 0, "R11");
         step(18'd0, 18'd0, 0, 1, 1, 0, 1, 0, "R11");
      end
      // sweep of controls and data in both directions
      r = 32'h1234_5678;
      for (int n = 0; n < 3000; n++) begin
         logic [W-1:0] da, db;
         r  = r * 32'd1664525 + 32'd1013904223;
         da = r[31:14];
         db = r[W-1:0] ^ r[31:14];
         step(da, db, r[3:0] == 4'd0, r[5], r[9] | r[10],
              r[7:4] == 4'd3, r[11], r[12] & r[13], "");
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule